// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Controller

This block collects 32 external interrupt inputs and steers each one to a single processor core and to one of that core's four parent interrupt lines. Each input has its own trigger setting: active-high level, active-low level, rising edge or falling edge. Each input also has an enable bit and a routing byte. The block drives a 4x4 grid of parent interrupt outputs. For each core it also offers a pending-status word, which that core's handler reads to find out which sources raised the line.

Software programs the block through a simple 32-bit register bus. A write lasts one cycle and uses byte enables. Reads are combinational on the address. Each routing byte sits at the byte offset equal to its source number, so a byte write changes one source's route. The enables are written through two strobe registers, one that sets bits and one that clears them, and they are read back from a separate status word. Every raw input passes through a two-flop synchronizer before edge detection. An edge-mode source holds its pending state in a latch until software either disables that source or switches it back to level mode.

Top module: `route_irq_ctrl`

## Requirements
- R1: After reset these all read as zero: the enable status (0x24), polarity (0x30), edge-select (0x34), every routing byte and every core status word. All parent outputs are low.
- R2: The routing byte of source i sits at byte offset i: it is bits [8*(i%4)+7 : 8*(i%4)] of the word at offset 4*(i/4). Bits [3:0] of the byte are a one-hot core field and bits [7:4] a one-hot line field. A write changes only the byte lanes whose byte enable is set, and the word reads back what was written.
- R3: Writing a word to 0x28 sets the enable bits where the data has ones, and writing to 0x2C clears them. Zero bits leave their enables unchanged. The enables read back at 0x24.
- R4: In level mode (edge bit 0), a source with polarity bit 0 is active while its input is high, and one with polarity bit 1 is active while its input is low. The outputs follow the input within three clock edges.
- R5: In edge mode (edge bit 1), polarity 0 latches a pending state on a rising input and polarity 1 on a falling input. The state stays after the input returns to its idle level.
- R6: A pending edge latch is cleared when its source's bit is written to 0x2C, or when its edge-select bit is cleared. Enabling the source again afterwards does not bring the latch back.
- R7: Bit i of the status word of core n, at offset 0x40 + 8*n, is 1 exactly when source i is enabled, is active, and has bit n set in its core field.
- R8: irq_out[4*c + p] is high exactly when some bit of core c's status word belongs to a source whose line field has bit p set. Several sources routed to the same line are ORed together.
- R9: Reads at undefined word offsets return zero. These include 0x20, 0x28, 0x2C, 0x38, 0x3C, 0x44 and any offset from 0x60 upward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Byte address; bits [7:2] pick the word |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_in | input | 32 | Raw asynchronous interrupt inputs |
| irq_out | output | 16 | Parent lines, index 4*core + line |

## Verification
The assertions assume that the enable strobes arrive as full-word writes, with all byte enables set. They also assume that reset is held low from time zero until the first clock edge. The bench always writes the enable words with all four byte enables and asserts reset before the clock starts. The bench also changes a source's polarity only while that source's edge detector sees a steady input. This keeps every latch event caused by a real edge on the input and never by a reconfiguration.

// File: rtl/ric_pkg.sv
// Package for the routed interrupt controller.
// Holds the word indices of the register map (byte address >> 2) and the
// width of the routing byte fields.
package ric_pkg;
    localparam int WORD_ENA_STS = 9;   // 0x24 enable readback
    localparam int WORD_ENA_SET = 10;  // 0x28 write-1-to-set
    localparam int WORD_ENA_CLR = 11;  // 0x2C write-1-to-clear
    localparam int WORD_POL     = 12;  // 0x30 polarity
    localparam int WORD_EDGE    = 13;  // 0x34 edge select
    localparam int WORD_ST_BASE = 16;  // 0x40 first core status word
    localparam int WORD_ST_STEP = 2;   // 8-byte stride between cores
    localparam int ROUTE_BITS   = 8;
    typedef logic [ROUTE_BITS-1:0] route_byte_t;
endpackage

// File: rtl/ric_front.sv
// Input front end: synchronizes the raw inputs, applies polarity, detects
// edges and holds the edge latches. Assumes the polarity only changes
// while the input is steady, because a flip would look like an edge.
module ric_front #(
    parameter int NSRC   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raw_in,
    input  logic [NSRC-1:0] pol_q,
    input  logic [NSRC-1:0] edge_q,
    input  logic [NSRC-1:0] drop_mask,
    output logic [NSRC-1:0] latch_q,
    output logic [NSRC-1:0] active
);
    logic [NSRC-1:0] sync_q [STAGES];
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] lvl_now, lvl_prev, hit;

    // Synchronizer chain, first stage samples the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= '0;
        else        sync_q[0] <= raw_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_sync
        // Further synchronizer stages
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= '0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    // Previous synchronized value, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Polarity-corrected level and its transition into the active state
    always_comb begin
        lvl_now  = sync_q[STAGES-1] ^ pol_q;
        lvl_prev = prev_q ^ pol_q;
        hit      = lvl_now & ~lvl_prev;
    end

    // Edge latch: sets on an event, cleared by a disable write or by level mode
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= edge_q & ~drop_mask & (latch_q | hit);
    end

    // Per-source active signal, chosen by the trigger mode
    always_comb active = (edge_q & latch_q) | (~edge_q & lvl_now);
endmodule

// File: rtl/ric_regs.sv
// Register file: routing bytes, enables, polarity and edge select, plus the
// read multiplexer. Assumes single-cycle writes; reads are combinational.
module ric_regs
    import ric_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCORE = 4,
    parameter int AW    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [3:0]              bus_be,
    input  logic [31:0]             bus_wdata,
    input  logic [NCORE-1:0][NSRC-1:0] core_status,
    output logic [31:0]             bus_rdata,
    output route_byte_t [NSRC-1:0]  route_q,
    output logic [NSRC-1:0]         en_q,
    output logic [NSRC-1:0]         pol_q,
    output logic [NSRC-1:0]         edge_q,
    output logic [NSRC-1:0]         drop_mask
);
    localparam int NWORDS = NSRC / 4;
    localparam int WW     = AW - 2;

    logic [WW-1:0] word;
    logic [31:0]   wmask;
    logic [NSRC-1:0] wdat;

    // Word index and byte-lane mask of the current access
    always_comb begin
        word  = bus_addr[AW-1:2];
        wmask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
        wdat  = NSRC'(bus_wdata & wmask);
    end

    // Enable bits to drop this cycle, shared with the edge latches
    always_comb drop_mask = (bus_we && word == WW'(WORD_ENA_CLR)) ? wdat : '0;

    for (genvar i = 0; i < NSRC; i++) begin : g_route
        // Routing byte of one source, written through its byte lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[i] <= '0;
            else if (bus_we && word == WW'(i / 4) && bus_be[i % 4])
                route_q[i] <= bus_wdata[8*(i%4) +: 8];
        end
    end

    // Enable bits through the set and clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (bus_we && word == WW'(WORD_ENA_SET))
            en_q <= en_q | wdat;
        else
            en_q <= en_q & ~drop_mask;
    end

    // Polarity and edge-select words, byte-lane masked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edge_q <= '0;
        end else if (bus_we) begin
            if (word == WW'(WORD_POL))
                pol_q <= (pol_q & ~NSRC'(wmask)) | wdat;
            if (word == WW'(WORD_EDGE))
                edge_q <= (edge_q & ~NSRC'(wmask)) | wdat;
        end
    end

    // Read multiplexer; undefined words return zero
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORDS; w++)
            if (word == WW'(w))
                bus_rdata = {route_q[4*w+3], route_q[4*w+2], route_q[4*w+1], route_q[4*w]};
        if (word == WW'(WORD_ENA_STS)) bus_rdata = 32'(en_q);
        if (word == WW'(WORD_POL))     bus_rdata = 32'(pol_q);
        if (word == WW'(WORD_EDGE))    bus_rdata = 32'(edge_q);
        for (int c = 0; c < NCORE; c++)
            if (word == WW'(WORD_ST_BASE + WORD_ST_STEP * c))
                bus_rdata = 32'(core_status[c]);
    end
endmodule

// File: rtl/ric_route.sv
// Routing fabric: builds each core's status word from enable, active and
// core field, then ORs it onto parent lines chosen by the line field.
// Purely combinational; assumes NCORE and NLINE each fit in four bits.
module ric_route
    import ric_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCORE = 4,
    parameter int NLINE = 4
) (
    input  route_byte_t [NSRC-1:0]     route_q,
    input  logic [NSRC-1:0]            en_q,
    input  logic [NSRC-1:0]            active,
    output logic [NCORE-1:0][NSRC-1:0] core_status,
    output logic [NCORE*NLINE-1:0]     lines
);
    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic [NSRC-1:0] to_core;
        // Sources whose core field names this core
        always_comb
            for (int i = 0; i < NSRC; i++) to_core[i] = route_q[i][c];
        always_comb core_status[c] = en_q & active & to_core;

        for (genvar p = 0; p < NLINE; p++) begin : g_line
            logic [NSRC-1:0] to_line;
            // Sources whose line field names this parent line
            always_comb
                for (int i = 0; i < NSRC; i++) to_line[i] = route_q[i][4+p];
            always_comb lines[c*NLINE + p] = |(core_status[c] & to_line);
        end
    end
endmodule

// File: rtl/route_irq_ctrl.sv
// Top of the routed interrupt controller. Joins the register file, input
// front end and routing fabric. Assumes irq_in may be asynchronous.
module route_irq_ctrl #(
    parameter int NSRC   = 32,
    parameter int NCORE  = 4,
    parameter int NLINE  = 4,
    parameter int STAGES = 2,
    parameter int AW     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [AW-1:0]          bus_addr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NSRC-1:0]        irq_in,
    output logic [NCORE*NLINE-1:0] irq_out
);
    ric_pkg::route_byte_t [NSRC-1:0] route_q;
    logic [NSRC-1:0] en_q, pol_q, edge_q, drop_mask, latch_q, active;
    logic [NCORE-1:0][NSRC-1:0] core_status;

    ric_regs #(.NSRC(NSRC), .NCORE(NCORE), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .core_status(core_status),
        .bus_rdata(bus_rdata), .route_q(route_q), .en_q(en_q),
        .pol_q(pol_q), .edge_q(edge_q), .drop_mask(drop_mask)
    );

    ric_front #(.NSRC(NSRC), .STAGES(STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .raw_in(irq_in), .pol_q(pol_q),
        .edge_q(edge_q), .drop_mask(drop_mask), .latch_q(latch_q),
        .active(active)
    );

    ric_route #(.NSRC(NSRC), .NCORE(NCORE), .NLINE(NLINE)) u_route (
        .route_q(route_q), .en_q(en_q), .active(active),
        .core_status(core_status), .lines(irq_out)
    );
endmodule

// File: rtl/ric_checker.sv
// Assertion checker for route_irq_ctrl, attached by bind. Assumes enable
// strobes are full-word writes and reset is low at the first edge.
module ric_checker #(
    parameter int NSRC  = 32,
    parameter int NOUT  = 16,
    parameter int AW    = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_we,
    input logic [AW-1:0]   bus_addr,
    input logic [3:0]      bus_be,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic [NOUT-1:0] irq_out,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] edge_q,
    input logic [NSRC-1:0] latch_q
);
    logic [AW-3:0] w;
    logic undef_word;
    // Decode of the word offsets that hold no readable register
    always_comb begin
        w = bus_addr[AW-1:2];
        undef_word = (w == 8) || (w == 10) || (w == 11) || (w == 14) || (w == 15)
                  || (w >= 16 && w[0]) || (w >= 24);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && edge_q == '0 && irq_out == '0));

    assert_set_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[AW-1:2] == 10 && bus_be == 4'hF)
        |=> ((en_q & NSRC'($past(bus_wdata))) == NSRC'($past(bus_wdata))));

    assert_clr_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[AW-1:2] == 11 && bus_be == 4'hF)
        |=> ((en_q & NSRC'($past(bus_wdata))) == '0));

    assert_level_mode_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latch_q & ~$past(edge_q)) == '0));

    assert_out_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> (en_q != '0));

    assert_undef_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_word |-> (bus_rdata == '0));
endmodule

bind route_irq_ctrl ric_checker #(.NSRC(NSRC), .NOUT(NCORE*NLINE), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .en_q(en_q), .edge_q(edge_q), .latch_q(latch_q)
);

// File: tb/sim_route_irq_ctrl.sv
// Directed bench for route_irq_ctrl: one task per scenario.
module sim_route_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [15:0] irq_out;
    int n_run = 0;
    int n_bad = 0;
    logic done = 1'b0;

    route_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R1 enable", 8'h24, 0);
        rd_check("R1 pol", 8'h30, 0);
        rd_check("R1 edge", 8'h34, 0);
        rd_check("R1 route", 8'h1C, 0);
        rd_check("R1 status", 8'h58, 0);
        check("R1 irq_out", 32'(irq_out), 0);
    endtask

    task automatic t_route();
        wr(8'h04, 4'b0010, 32'hAAAA_21BB);
        rd_check("R2 lane write", 8'h04, 32'h0000_2100);
        wr(8'h04, 4'b1000, 32'h4800_0000);
        rd_check("R2 second lane", 8'h04, 32'h4800_2100);
        wr(8'h04, 4'b1000, 32'h0);
    endtask

    task automatic t_enable();
        wr(8'h28, 4'hF, 32'h0000_00F0);
        rd_check("R3 set", 8'h24, 32'h0000_00F0);
        wr(8'h28, 4'hF, 32'h0000_0001);
        rd_check("R3 set keeps others", 8'h24, 32'h0000_00F1);
        wr(8'h2C, 4'hF, 32'h0000_0031);
        rd_check("R3 clear", 8'h24, 32'h0000_00C0);
        wr(8'h2C, 4'hF, 32'hFFFF_FFFF);
        rd_check("R3 clear all", 8'h24, 0);
    endtask

    task automatic t_level();
        wr(8'h04, 4'b0010, 32'h0000_2100);   // source 5: core 0, line 1
        wr(8'h28, 4'hF, 32'h0000_0020);
        irq_in[5] = 1'b1; settle();
        check("R4 high active", 32'(irq_out), 32'h0002);
        rd_check("R7 core0 status", 8'h40, 32'h0000_0020);
        rd_check("R7 other core", 8'h48, 0);
        irq_in[5] = 1'b0; settle();
        check("R4 high released", 32'(irq_out), 0);
        wr(8'h30, 4'hF, 32'h0000_0020);
        settle();
        check("R4 low active", 32'(irq_out), 32'h0002);
        irq_in[5] = 1'b1; settle();
        check("R4 low released", 32'(irq_out), 0);
        wr(8'h2C, 4'hF, 32'h0000_0020);
        irq_in[5] = 1'b0; settle();
        check("R7 disabled hides", 32'(irq_out), 0);
        wr(8'h30, 4'hF, 0);
    endtask

    task automatic t_edge();
        wr(8'h08, 4'b0010, 32'h0000_8400);   // source 9: core 2, line 3
        wr(8'h34, 4'hF, 32'h0000_0200);
        wr(8'h28, 4'hF, 32'h0000_0200);
        settle();
        check("R5 idle", 32'(irq_out), 0);
        irq_in[9] = 1'b1; repeat (2) @(negedge clk); irq_in[9] = 1'b0;
        settle();
        check("R5 rising latched", 32'(irq_out), 32'h0800);
        rd_check("R7 core2 status", 8'h50, 32'h0000_0200);
        wr(8'h2C, 4'hF, 32'h0000_0200);
        wr(8'h28, 4'hF, 32'h0000_0200);
        settle();
        check("R6 disable clears", 32'(irq_out), 0);
        wr(8'h30, 4'hF, 32'h0000_0200);
        irq_in[9] = 1'b1; settle();
        check("R5 falling waits", 32'(irq_out), 0);
        irq_in[9] = 1'b0; settle();
        check("R5 falling latched", 32'(irq_out), 32'h0800);
        irq_in[9] = 1'b1; settle();
        check("R5 held after idle", 32'(irq_out), 32'h0800);
        wr(8'h34, 4'hF, 0);
        settle();
        check("R6 level mode clears", 32'(irq_out), 0);
        wr(8'h34, 4'hF, 32'h0000_0200);
        settle();
        check("R6 latch not revived", 32'(irq_out), 0);
        wr(8'h34, 4'hF, 0);
        wr(8'h30, 4'hF, 0);
        wr(8'h2C, 4'hF, 32'hFFFF_FFFF);
        irq_in[9] = 1'b0;
    endtask

    task automatic t_merge();
        wr(8'h00, 4'b1001, 32'h1200_0012);   // sources 0 and 3: core 1, line 0
        wr(8'h28, 4'hF, 32'h0000_0009);
        irq_in[0] = 1'b1; irq_in[3] = 1'b1; settle();
        check("R8 both", 32'(irq_out), 32'h0010);
        rd_check("R7 core1 status", 8'h48, 32'h0000_0009);
        irq_in[0] = 1'b0; settle();
        check("R8 one left", 32'(irq_out), 32'h0010);
        irq_in[3] = 1'b0; settle();
        check("R8 none", 32'(irq_out), 0);
    endtask

    task automatic t_undef();
        rd_check("R9 0x20", 8'h20, 0);
        rd_check("R9 0x28", 8'h28, 0);
        rd_check("R9 0x38", 8'h38, 0);
        rd_check("R9 0x44", 8'h44, 0);
        rd_check("R9 0x60", 8'h60, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_route();
        t_enable();
        t_level();
        t_edge();
        t_merge();
        t_undef();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule